// File: doc/BRIEF.md
# Rotate-and-Mask Unit

This block is the combinational data path behind rotate-left-then-mask operations of an integer execution unit. A source word is rotated left by a shift count. In parallel, a mask is built from a begin index and an end index. The unit returns the rotated value, the mask, and the rotated value with all bits outside the mask cleared.

Bit indices follow MSB-first numbering: index 0 names the most significant bit and index 63 the least significant. When begin is greater than end, the mask wraps around the word. A word-mode input selects 32-bit operation. In that mode the low word is copied into both halves before the rotate, and both mask indices are moved into the low half of the register.

There is no state and no pipelining. Every output settles in the same cycle as its inputs.

Top module: `rotmask_unit`

## Requirements
- R1: With word32_i=0 and begin_i <= end_i, mask_o has ones exactly at MSB-first indices begin_i..end_i inclusive (index i is LSB bit 63-i), e.g. begin 37, end 63 gives 0x0000000007FFFFFF and begin 0, end 37 gives 0xFFFFFFFFFC000000.
- R2: With begin_i > end_i (effective indices), mask_o has ones at indices begin..63 and 0..end, e.g. 47,37 gives 0xFFFFFFFFFC01FFFF and 62,34 gives 0xFFFFFFFFE0000003; end = begin-1 gives all ones.
- R3: Equal effective begin and end give exactly one set bit, e.g. 32,32 gives 0x80000000 and 33,33 gives 0x40000000.
- R4: With word32_i=0, rot_o is src_i rotated toward the MSB by amt_i (6 bits, modulo 64), e.g. 0xDEADBEEF12345678 by 10 gives 0xB6FBBC48D159E37A and by 35 gives 0x91A2B3C6F56DF778. A count of 0 passes src_i unchanged.
- R5: With word32_i=1, the unit rotates {src_i[31:0], src_i[31:0]} by amt_i. The upper halves of rot_o equal each other, and src_i[63:32] has no effect on any output.
- R6: With word32_i=1, each mask index is 32 plus its low 5 bits (begin_i[5] and end_i[5] are ignored).
- R7: res_o equals rot_o AND mask_o in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Source word |
| amt_i | input | 6 | Left-rotate count |
| begin_i | input | 6 | Mask begin index, MSB-first |
| end_i | input | 6 | Mask end index, MSB-first |
| word32_i | input | 1 | 1 selects 32-bit word mode |
| rot_o | output | 64 | Rotated value |
| mask_o | output | 64 | Generated mask |
| res_o | output | 64 | Rotated value AND mask |

## Verification
The unit is tested in four ways:
- Every one of the 4096 begin/end pairs is swept in 64-bit mode. This tells the contiguous, wrapped and single-bit mask shapes apart at every boundary.
- The same sweep is run in 32-bit mode. This shows that the top index bits are dropped and the offset is applied.
- Random sources and rotate counts in both modes expose rotate stages that are wrong or swapped, since each count bit drives its own stage.
- Directed pairs of operands that differ only in the upper source half or in the index top bits show that those inputs are ignored in 32-bit mode.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
   localparam int unsigned RM_DATA_W = 64;
   localparam int unsigned RM_IDX_W  = $clog2(RM_DATA_W);

   typedef enum logic {
      RM_MODE_WIDE   = 1'b0,
      RM_MODE_NARROW = 1'b1
   } rm_mode_e;
endpackage

// File: rtl/rm_word_prep.sv
module rm_word_prep #(
   parameter int unsigned DATA_W        = 64,
   parameter bit          HAS_WORD_MODE = 1'b1,
   localparam int unsigned IDX_W        = $clog2(DATA_W),
   localparam int unsigned HALF_W       = DATA_W / 2
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [IDX_W-1:0]  beg_i,
   input  logic [IDX_W-1:0]  fin_i,
   input  logic              narrow_i,
   output logic [DATA_W-1:0] word_o,
   output logic [IDX_W-1:0]  beg_o,
   output logic [IDX_W-1:0]  fin_o
);
   generate
      if (HAS_WORD_MODE) begin : g_word_mode
         always_comb begin
            if (narrow_i) begin
               word_o = {src_i[HALF_W-1:0], src_i[HALF_W-1:0]};
               beg_o  = {1'b1, beg_i[IDX_W-2:0]};
               fin_o  = {1'b1, fin_i[IDX_W-2:0]};
            end else begin
               word_o = src_i;
               beg_o  = beg_i;
               fin_o  = fin_i;
            end
         end
      end else begin : g_wide_only
         logic unused_narrow;
         assign unused_narrow = narrow_i;
         assign word_o = src_i;
         assign beg_o  = beg_i;
         assign fin_o  = fin_i;
      end
   endgenerate
endmodule

// File: rtl/rm_rotator.sv
module rm_rotator #(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic [IDX_W-1:0]  amt_i,
   output logic [DATA_W-1:0] rot_o
);
   logic [DATA_W-1:0] stage [IDX_W+1];

   assign stage[0] = word_i;

   generate
      for (genvar k = 0; k < IDX_W; k++) begin : g_stage
         localparam int unsigned SH = 1 << k;
         logic [DATA_W-1:0] turned;
         assign turned = {stage[k][DATA_W-1-SH:0], stage[k][DATA_W-1:DATA_W-SH]};
         assign stage[k+1] = amt_i[k] ? turned : stage[k];
      end
   endgenerate

   assign rot_o = stage[IDX_W];
endmodule

// File: rtl/rm_mask_gen.sv
module rm_mask_gen #(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned IDX_W = $clog2(DATA_W)
) (
   input  logic [IDX_W-1:0]  beg_i,
   input  logic [IDX_W-1:0]  fin_i,
   output logic [DATA_W-1:0] mask_o
);
   logic wraps;
   assign wraps = beg_i > fin_i;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         localparam logic [IDX_W-1:0] POS = IDX_W'(i);
         logic at_or_after_beg;
         logic at_or_before_fin;
         assign at_or_after_beg  = POS >= beg_i;
         assign at_or_before_fin = POS <= fin_i;
         assign mask_o[DATA_W-1-i] = wraps ? (at_or_after_beg | at_or_before_fin)
                                           : (at_or_after_beg & at_or_before_fin);
      end
   endgenerate
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
   import rotmask_pkg::*;
#(
   parameter int unsigned DATA_W        = RM_DATA_W,
   parameter bit          HAS_WORD_MODE = 1'b1,
   localparam int unsigned IDX_W        = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [IDX_W-1:0]  amt_i,
   input  logic [IDX_W-1:0]  begin_i,
   input  logic [IDX_W-1:0]  end_i,
   input  logic              word32_i,
   output logic [DATA_W-1:0] rot_o,
   output logic [DATA_W-1:0] mask_o,
   output logic [DATA_W-1:0] res_o
);
   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("rotmask_unit: DATA_W must be a power of two, at least 8");
      end
   endgenerate

   logic [DATA_W-1:0] word;
   logic [IDX_W-1:0]  eff_beg;
   logic [IDX_W-1:0]  eff_fin;

   rm_word_prep #(.DATA_W(DATA_W), .HAS_WORD_MODE(HAS_WORD_MODE)) u_prep (
      .src_i    (src_i),
      .beg_i    (begin_i),
      .fin_i    (end_i),
      .narrow_i (word32_i == RM_MODE_NARROW),
      .word_o   (word),
      .beg_o    (eff_beg),
      .fin_o    (eff_fin)
   );

   rm_rotator #(.DATA_W(DATA_W)) u_rot (
      .word_i (word),
      .amt_i  (amt_i),
      .rot_o  (rot_o)
   );

   rm_mask_gen #(.DATA_W(DATA_W)) u_mask (
      .beg_i  (eff_beg),
      .fin_i  (eff_fin),
      .mask_o (mask_o)
   );

   assign res_o = rot_o & mask_o;
endmodule

// File: rtl/rotmask_chk.sv
module rotmask_chk #(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned IDX_W  = $clog2(DATA_W),
   localparam int unsigned HALF_W = DATA_W / 2
) (
   input logic [DATA_W-1:0] src_i,
   input logic [IDX_W-1:0]  amt_i,
   input logic [IDX_W-1:0]  begin_i,
   input logic [IDX_W-1:0]  end_i,
   input logic              word32_i,
   input logic [DATA_W-1:0] rot_o,
   input logic [DATA_W-1:0] mask_o,
   input logic [DATA_W-1:0] res_o
);
   logic [IDX_W-1:0] cb, ce;
   logic             known;

   always_comb begin
      cb    = word32_i ? {1'b1, begin_i[IDX_W-2:0]} : begin_i;
      ce    = word32_i ? {1'b1, end_i[IDX_W-2:0]}   : end_i;
      known = !$isunknown({src_i, amt_i, begin_i, end_i, word32_i});
   end

   always_comb begin
      if (known) begin
         // R7: result carries no bit outside the mask or the rotated value
         p_res_within_r7: assert ((res_o & ~mask_o) == '0 && (res_o & ~rot_o) == '0);
         // R7: every bit of both inside the mask survives
         p_res_keeps_r7: assert ((rot_o & mask_o & ~res_o) == '0);
         // R3: equal indices give a single bit at the begin position
         if (cb == ce) p_single_bit_r3: assert ($countones(mask_o) == 1 && mask_o[DATA_W-1-cb]);
         // R2: end one below begin wraps to a full mask
         if (cb == ce + 1'b1) p_full_wrap_r2: assert (&mask_o);
         // R1/R2: the begin and end positions are always inside the mask
         p_ends_set_r1: assert (mask_o[DATA_W-1-cb] && mask_o[DATA_W-1-ce]);
         // R4: zero count passes the source through in wide mode
         if (!word32_i && amt_i == '0) p_zero_pass_r4: assert (rot_o == src_i);
         // R5: narrow mode yields equal halves of the rotated value
         if (word32_i) p_halves_equal_r5: assert (rot_o[DATA_W-1:HALF_W] == rot_o[HALF_W-1:0]);
         // R6: narrow mode mask lies wholly in the low half unless it wraps
         if (word32_i && cb <= ce) p_low_half_r6: assert (mask_o[DATA_W-1:HALF_W] == '0);
      end
   end
endmodule

bind rotmask_unit rotmask_chk #(.DATA_W(DATA_W)) u_rotmask_chk (
   .src_i    (src_i),
   .amt_i    (amt_i),
   .begin_i  (begin_i),
   .end_i    (end_i),
   .word32_i (word32_i),
   .rot_o    (rot_o),
   .mask_o   (mask_o),
   .res_o    (res_o)
);

// File: tb/tb_rotmask_unit.sv
`timescale 1ns/1ps
module tb_rotmask_unit;
   logic        clk = 1'b0;
   logic [63:0] src = '0;
   logic [5:0]  amt = '0, bg = '0, en = '0;
   logic        w32 = 1'b0;
   logic [63:0] rot, mask, res;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rotmask_unit dut (
      .src_i(src), .amt_i(amt), .begin_i(bg), .end_i(en), .word32_i(w32),
      .rot_o(rot), .mask_o(mask), .res_o(res)
   );

   function automatic logic [63:0] ref_mask(int b, int e);
      logic [63:0] m = '0;
      for (int i = 0; i < 64; i++) begin
         if (b <= e) m[63-i] = (i >= b) && (i <= e);
         else        m[63-i] = (i >= b) || (i <= e);
      end
      return m;
   endfunction

   function automatic logic [63:0] ref_rot(logic [63:0] x, int n);
      logic [63:0] y = x;
      for (int k = 0; k < (n % 64); k++) y = {y[62:0], y[63]};
      return y;
   endfunction

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(logic [63:0] s, int a, int b, int e, bit n32);
      @(posedge clk);
      #1;
      src = s; amt = 6'(a); bg = 6'(b); en = 6'(e); w32 = n32;
      @(negedge clk);
   endtask

   // full model comparison, tagged with the requirement under test
   task automatic compare_all(string req);
      logic [63:0] x, er, em;
      int b, e;
      x  = w32 ? {src[31:0], src[31:0]} : src;
      b  = w32 ? 32 + int'(bg[4:0]) : int'(bg);
      e  = w32 ? 32 + int'(en[4:0]) : int'(en);
      er = ref_rot(x, int'(amt));
      em = ref_mask(b, e);
      check(req, "rot", rot, er);
      check(req, "mask", mask, em);
      check("R7", "res", res, er & em);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] r0;
      logic [63:0] m0;
      logic [63:0] z0;
      // initial state: all inputs zero
      @(negedge clk);
      check("R4", "initial rot", rot, 64'h0);
      check("R3", "initial mask", mask, 64'h8000000000000000);

      // R1 directed
      apply('1, 0, 37, 63, 0); check("R1", "mask 37..63", mask, 64'h0000000007FFFFFF);
      apply('1, 0, 0, 37, 0);  check("R1", "mask 0..37", mask, 64'hFFFFFFFFFC000000);
      apply('1, 0, 58, 63, 0); check("R1", "mask 58..63", mask, 64'h000000000000003F);
      // R2 directed
      apply('1, 0, 47, 37, 0); check("R2", "mask 47,37", mask, 64'hFFFFFFFFFC01FFFF);
      apply('1, 0, 62, 34, 0); check("R2", "mask 62,34", mask, 64'hFFFFFFFFE0000003);
      apply('1, 0, 20, 19, 0); check("R2", "mask full wrap", mask, '1);
      // R3 directed
      apply('1, 0, 32, 32, 0); check("R3", "mask 32,32", mask, 64'h80000000);
      apply('1, 0, 33, 33, 0); check("R3", "mask 33,33", mask, 64'h40000000);
      // R4 directed
      apply(64'hDEADBEEF12345678, 10, 0, 63, 0); check("R4", "rot 10", rot, 64'hB6FBBC48D159E37A);
      apply(64'hDEADBEEF12345678, 35, 0, 63, 0); check("R4", "rot 35", rot, 64'h91A2B3C6F56DF778);
      apply(64'hDEADBEEF12345678, 0, 0, 63, 0);  check("R4", "rot 0", rot, 64'hDEADBEEF12345678);
      // R5: upper source half ignored
      apply(64'h0123456789ABCDEF, 13, 3, 28, 1);
      r0 = rot; m0 = mask; z0 = res;
      apply(64'hFEDCBA9889ABCDEF, 13, 3, 28, 1);
      check("R5", "rot upper src ignored", rot, r0);
      check("R5", "res upper src ignored", res, z0);
      check("R5", "rot duplicated", rot, ref_rot(64'h89ABCDEF89ABCDEF, 13));
      // R6: top index bits ignored, offset applied
      apply(64'h0123456789ABCDEF, 13, 35, 60, 1);
      check("R6", "mask top bits ignored", mask, m0);
      check("R6", "mask offset", mask, ref_mask(35, 60));
      apply('1, 0, 0, 0, 1); check("R6", "mask 0,0 narrow", mask, 64'h80000000);

      // exhaustive begin/end sweep, both modes
      for (int m = 0; m < 2; m++)
         for (int b = 0; b < 64; b++)
            for (int e = 0; e < 64; e++) begin
               apply(64'hDEADBEEF12345678, (b + e) % 64, b, e, m[0]);
               compare_all(b <= e ? "R1" : "R2");
            end

      // random operands, both modes
      for (int t = 0; t < 3000; t++) begin
         apply({$urandom, $urandom}, $urandom % 64, $urandom % 64, $urandom % 64, t[0]);
         compare_all(t[0] ? "R5" : "R4");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule